// File: doc/BRIEF.md
# Load/Store Lane Aligner

This block connects the load/store side of a 64-bit processor to a 32-bit system bus. One processor request of 8, 16, 32 or 64 bits becomes one or two 32-bit bus beats. A load always reads whole aligned words. The block then selects the requested byte or halfword from the returned word and widens the result to 64 bits, with sign or zero extension as the request asks.

A store moves the register value into the byte lanes that match the address offset. Lanes are big-endian: offset 0 is bits 31:24 and offset 3 is bits 7:0. Register bytes that fall outside the addressed lane are not cleared, so they reach the bus unchanged. The bus target decides which bytes to write. To do this it uses the full address, including its two low bits, and the size code. Both travel with every beat.

A request whose address is not a multiple of its size is refused before any bus activity, and the block answers it with an exception response. While a transfer is in flight the processor side sees `busy`. The block accepts no new request until the final beat has been taken by the bus.

Top module: `lsu_lane_aligner`

## Requirements
- R1: A request whose address is not a multiple of its size in bytes produces, one cycle after acceptance, a response with `rsp_exc`=1 and `rsp_rdata`=0. It issues no bus beat.
- R2: An aligned request of 8, 16 or 32 bits issues exactly one bus beat. `bus_addr` is the request address, `bus_size` is the request size code (0=8, 1=16, 2=32, 3=64 bits) and `bus_write` is the request direction.
- R3: An aligned 64-bit request issues two beats, at the address and then at address+4. A store sends register bits 63:32 first and bits 31:0 second. A load returns the first word in `rsp_rdata[63:32]` and the second in `rsp_rdata[31:0]`.
- R4: A byte load returns bits [31-8*offset -: 8] of the returned word, where offset is address bits 1:0.
- R5: A halfword load returns `bus_rdata[31:16]` when address bit 1 is 0 and `bus_rdata[15:0]` when it is 1.
- R6: A load with `req_signed`=1 sign-extends the 8, 16 or 32-bit field to 64 bits. With `req_signed`=0 it zero-extends the field.
- R7: A byte store drives `bus_wdata` = register bits 31:0 shifted left by 8*(3-offset) and truncated to 32 bits, with no masking of the other lanes.
- R8: A halfword store drives register bits 31:0 shifted left by 16 when address bit 1 is 0, and unshifted when it is 1. A word store drives register bits 31:0 unshifted.
- R9: `req_ready` is high exactly when `busy` is low. `busy` rises in the cycle after an aligned request is accepted and stays high until the last beat handshake. `rsp_valid` pulses for one cycle directly after that handshake, and `busy` is then low. After reset `busy`, `bus_valid` and `rsp_valid` are low.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0=8, 1=16, 2=32, 3=64 bits |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store register value |
| busy | output | 1 | Transfer in flight |
| rsp_valid | output | 1 | Completion pulse |
| rsp_exc | output | 1 | Address exception on completion |
| rsp_rdata | output | 64 | Extended load result |
| bus_valid | output | 1 | Bus beat present |
| bus_ready | input | 1 | Bus accepts beat |
| bus_write | output | 1 | Beat direction |
| bus_size | output | 2 | Size code of the original access |
| bus_addr | output | ADDR_W | Beat address with original low bits |
| bus_wdata | output | 32 | Store lane data |
| bus_rdata | input | 32 | Read word, valid during handshake |

## Verification
The bench builds the block with the default 32-bit address width. That width is enough to sweep every size against all eight offsets inside a doubleword, at three base addresses, for loads and stores. The bus side stalls in irregular single and multi-cycle bursts, so held beats and the gap between the two halves of a doubleword are both covered. The read data is a hash of the word address, so byte and halfword fields with both sign-bit values come up in the sweep.

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_exc,
  output logic [63:0]       rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [1:0]        bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} state_t;

  state_t            state;
  logic              write_q, signed_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [63:0]       wdata_q;
  logic [31:0]       hi_q;

  logic        misalign, accept, beat_done;
  logic [1:0]  off;
  logic [31:0] byte_sh;
  logic [7:0]  byte_f;
  logic [15:0] half_f;
  logic [63:0] load_ext;

  assign misalign = (req_size == SZ_H && req_addr[0]) ||
                    (req_size == SZ_W && |req_addr[1:0]) ||
                    (req_size == SZ_D && |req_addr[2:0]);

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign accept    = req_valid && req_ready;
  assign beat_done = bus_valid && bus_ready;

  assign off       = addr_q[1:0];
  assign bus_valid = busy;
  assign bus_write = write_q;
  assign bus_size  = size_q;
  assign bus_addr  = (state == S_SECOND) ? {addr_q[ADDR_W-1:3], 3'b100} : addr_q;

  always_comb begin
    case (size_q)
      SZ_B:    bus_wdata = wdata_q[31:0] << {~off, 3'b000};
      SZ_H:    bus_wdata = wdata_q[31:0] << {~off[1], 4'b0000};
      SZ_W:    bus_wdata = wdata_q[31:0];
      default: bus_wdata = (state == S_SECOND) ? wdata_q[31:0] : wdata_q[63:32];
    endcase
  end

  assign byte_sh = bus_rdata >> {~off, 3'b000};
  assign byte_f  = byte_sh[7:0];
  assign half_f  = off[1] ? bus_rdata[15:0] : bus_rdata[31:16];

  always_comb begin
    case (size_q)
      SZ_B:    load_ext = {{56{signed_q & byte_f[7]}}, byte_f};
      SZ_H:    load_ext = {{48{signed_q & half_f[15]}}, half_f};
      default: load_ext = {{32{signed_q & bus_rdata[31]}}, bus_rdata};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      write_q   <= 1'b0;
      signed_q  <= 1'b0;
      size_q    <= SZ_B;
      addr_q    <= '0;
      wdata_q   <= '0;
      hi_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_exc   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_exc   <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (misalign) begin
            rsp_valid <= 1'b1;
            rsp_exc   <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            write_q  <= req_write;
            signed_q <= req_signed;
            size_q   <= req_size;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            state    <= S_FIRST;
          end
        end
        S_FIRST: if (beat_done) begin
          hi_q <= bus_rdata;
          if (size_q == SZ_D) begin
            state <= S_SECOND;
          end else begin
            state     <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= write_q ? 64'd0 : load_ext;
          end
        end
        S_SECOND: if (beat_done) begin
          state     <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= write_q ? 64'd0 : {hi_q, bus_rdata};
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_lane_aligner_chk.sv
module lsu_lane_aligner_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_exc,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata
);
  logic [2:0] size_mask;
  logic       bad_req;
  assign size_mask = (3'd1 << req_size) - 3'd1;
  assign bad_req   = (req_addr[2:0] & size_mask) != 3'd0;

  AST_MISALIGN_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && bad_req |=> !bus_valid && rsp_valid && rsp_exc); // R1

  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_size == 2'd1 |-> !bus_addr[0]); // R2

  AST_DWORD_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_size == 2'd3 && !bus_addr[2]
    |=> bus_valid && bus_addr == $past(bus_addr) + ADDR_W'(4)); // R3

  AST_RSP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && (bus_size != 2'd3 || bus_addr[2])
    |=> rsp_valid && !rsp_exc && !busy); // R9

  AST_NO_BEAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid); // R9

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata)); // R10
endmodule

bind lsu_lane_aligner lsu_lane_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .req_addr(req_addr), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_exc(rsp_exc), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/lsu_lane_aligner_test.sv
module lsu_lane_aligner_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, busy, rsp_valid, rsp_exc, bus_valid, bus_write;
  logic [63:0] rsp_rdata;
  logic [1:0] bus_size;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_ready = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #2 clk = ~clk;

  lsu_lane_aligner #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_signed(req_signed),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_exc(rsp_exc), .rsp_rdata(rsp_rdata), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic [31:0] wdata;
    string       tag;
  } beat_t;
  typedef struct {
    logic        exc;
    logic [63:0] data;
    string       tag;
  } rsp_t;

  beat_t bq[$];
  rsp_t  rq[$];
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  logic held = 1'b0;
  logic [31:0] held_addr, held_wdata;

  function automatic logic [31:0] mem(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] load_exp(input logic [31:0] a, input logic [1:0] sz, input bit sg);
    logic [31:0] w;
    logic [7:0] b;
    logic [15:0] h;
    int o;
    w = mem(a);
    o = int'(a[1:0]);
    b = w[31-8*o -: 8];
    h = (o >= 2) ? w[15:0] : w[31:16];
    case (sz)
      2'd0: return sg ? 64'($signed(b)) : {56'd0, b};
      2'd1: return sg ? 64'($signed(h)) : {48'd0, h};
      2'd2: return sg ? 64'($signed(w)) : {32'd0, w};
      default: return {mem(a), mem(a + 32'd4)};
    endcase
  endfunction

  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                       input bit sg, input logic [63:0] v);
    beat_t b;
    rsp_t r;
    int o;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_signed = sg; req_wdata = v;
    o = int'(a[1:0]);
    if ((a % (32'd1 << sz)) != 0) begin
      r.exc = 1'b1; r.data = '0; r.tag = "R1";
      rq.push_back(r);
    end else begin
      b.addr = a; b.size = sz; b.wr = wr;
      case (sz)
        2'd0: begin b.wdata = 32'(v[31:0] * (32'd1 << (8*(3-o)))); b.tag = "R7"; end
        2'd1: begin b.wdata = (o >= 2) ? v[31:0] : {v[15:0], 16'd0}; b.tag = "R8"; end
        2'd2: begin b.wdata = v[31:0]; b.tag = "R8"; end
        default: begin b.wdata = v[63:32]; b.tag = "R3"; end
      endcase
      if (sz != 2'd3) b.tag = wr ? b.tag : "R2";
      bq.push_back(b);
      if (sz == 2'd3) begin
        b.addr = a + 32'd4; b.wdata = v[31:0]; b.tag = "R3";
        bq.push_back(b);
      end
      r.exc = 1'b0;
      r.data = wr ? 64'd0 : load_exp(a, sz, sg);
      r.tag = wr ? "R9" : (sz == 2'd0) ? "R4" : (sz == 2'd1) ? "R5" : (sz == 2'd2) ? "R6" : "R3";
      if (!wr && sg && sz != 2'd3) r.tag = "R6";
      rq.push_back(r);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    beat_t b;
    rsp_t r;
    logic rdy;
    if (rst_n && !finished) begin
      cyc++;
      rdy = ((cyc % 23) >= 3) && ((cyc % 5) != 2);
      bus_ready = rdy;
      bus_rdata = mem(bus_addr);
      if (held) begin
        check(bus_valid && bus_addr == held_addr && bus_wdata == held_wdata, "R10",
              "beat held under stall", {bus_addr, bus_wdata}, {held_addr, held_wdata});
      end
      held = bus_valid && !rdy;
      held_addr = bus_addr; held_wdata = bus_wdata;
      if (bus_valid && rdy) begin
        check(busy, "R9", "busy during beat", 64'(busy), 64'd1);
        if (bq.size() == 0) begin
          check(1'b0, "R1", "unexpected bus beat", 64'(bus_addr), 64'd0);
        end else begin
          b = bq.pop_front();
          check(bus_addr == b.addr && bus_size == b.size && bus_write == b.wr, b.tag,
                "beat addr/size/dir", {bus_addr, 29'd0, bus_size, bus_write},
                {b.addr, 29'd0, b.size, b.wr});
          if (b.wr) check(bus_wdata == b.wdata, b.tag, "store lanes", 64'(bus_wdata), 64'(b.wdata));
        end
      end
      if (rsp_valid) begin
        if (rq.size() == 0) begin
          check(1'b0, "R9", "unexpected response", rsp_rdata, 64'd0);
        end else begin
          r = rq.pop_front();
          check(rsp_exc == r.exc && rsp_rdata == r.data, r.tag, "response",
                {rsp_rdata[62:0], rsp_exc}, {r.data[62:0], r.exc});
          check(!busy && req_ready, "R9", "idle at response", {62'd0, busy, req_ready}, 64'd1);
        end
      end
    end
  end

  initial begin
    logic [31:0] bases [3];
    logic [63:0] v;
    bases[0] = 32'h0000_0100; bases[1] = 32'h0000_2468; bases[2] = 32'h0040_7FF8;
    repeat (4) @(negedge clk);
    check(!busy && !bus_valid && !rsp_valid && req_ready, "R9", "reset state",
          {60'd0, busy, bus_valid, rsp_valid, req_ready}, 64'd1);
    rst_n = 1'b1;
    for (int bi = 0; bi < 3; bi++)
      for (int sz = 0; sz < 4; sz++)
        for (int o = 0; o < 8; o++)
          for (int k = 0; k < 3; k++) begin
            v = {32'hF1E2D3C4 ^ 32'(bi * 977 + o), 32'h8596A7B8 + 32'(sz * 4099 + o * 131)};
            issue(bases[bi] + 32'(o), 2'(sz), k == 2, k == 1, v);
          end
    repeat (40) @(negedge clk);
    check(bq.size() == 0 && rq.size() == 0, "R9", "all traffic drained",
          64'(bq.size() + rq.size()), 64'd0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule